// File: doc/BRIEF.md
# Multi-Channel Reloadable Down-Counter Unit with Timestamp

This unit sits on a simple 32-bit register bus and offers three independent down-counting channels plus one wide, free-running timestamp counter. Two channels are 16 bits wide and the third is 32 bits wide. A channel counts on a tick-enable pulse. A control bit chooses between a fast tick input and a slow one. When a channel passes zero it raises an interrupt line. That line stays high until software writes to the channel's clear register. In periodic mode the channel reloads from its load register, so a load value N gives a period of N+1 ticks. Otherwise it wraps to its all-ones value.

The timestamp counter counts up by one on each pulse of its own tick input while its enable bit is set. It never interrupts. Software reads the low word first. That read also latches the upper bits, so a later read of the high word gives a consistent snapshot of the whole count. All counting is gated by single-cycle tick-enable pulses in the bus clock domain. No derived clocks are used.

Top module: `tmr_unit`

## Requirements
- R1: Each channel control word uses bit 7 for run, bit 6 for periodic and bit 3 for fast-tick select. A read returns those three bits and zero elsewhere. A channel whose run bit is clear holds its count.
- R2: A running channel decrements by one on each pulse of its selected tick: tick_fast when bit 3 is 1, tick_slow when bit 3 is 0. Its value register reads back the count.
- R3: In periodic mode, a tick at count zero reloads the load value, so a load of N repeats every N+1 selected ticks.
- R4: With periodic clear, a tick at count zero wraps the count to all ones of the channel width.
- R5: A tick at count zero sets the channel's irq bit on the next clock edge, and the bit stays set until it is cleared.
- R6: A write of any data to a channel's clear register drops its irq on the next edge. If an underflow happens in the same cycle, the set wins.
- R7: A write to a load register updates both the load value and the count on the next edge, and takes priority over a tick in the same cycle. Writes to value registers are ignored.
- R8: Channels 1 and 2 are 16 bits wide and channel 3 is 32 bits wide. Load data is truncated to the channel width, and reads are zero-extended.
- R9: Channel register offsets are load +0x0, value +0x4, control +0x8 and clear +0xC, from channel bases 0x00, 0x20 and 0x80.
- R10: The timestamp counter increments on each tick_stamp pulse while enabled. A write to 0x64 sets the enable from data bit 8.
- R11: A read of 0x60 returns the low timestamp bits and latches the upper bits. A read of 0x64 returns the latched upper bits in bits 7:0 and the enable in bit 8.
- R12: Read data appears on bus_rdata one cycle after bus_rd and reflects the state before that edge. It is zero when there is no read and for unmapped addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte address within the unit |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tick_fast | input | 1 | Fast count-enable pulse |
| tick_slow | input | 1 | Slow count-enable pulse |
| tick_stamp | input | 1 | Timestamp count-enable pulse |
| irq | output | 3 | Sticky underflow interrupt, one bit per channel |

## Verification
The bench keeps the default channel widths. Loading zero therefore reaches the 16-bit and 32-bit all-ones wrap within a tick. The timestamp is built with STAMP_W=14 and STAMP_LO_W=6. The latched upper byte then changes every 64 stamp ticks, which brings the snapshot of a carry into the high word, and the high word's own wrap, within a short run. That would be out of reach with a 32-bit low word.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int NCH    = 3;
    localparam int BUS_W  = 32;
    localparam int ADDR_W = 8;

    localparam int CTL_RUN_BIT  = 7;
    localparam int CTL_PER_BIT  = 6;
    localparam int CTL_FAST_BIT = 3;
    localparam int STAMP_EN_BIT = 8;

    localparam logic [ADDR_W-1:0] STAMP_LO_ADDR = 8'h60;
    localparam logic [ADDR_W-1:0] STAMP_HI_ADDR = 8'h64;

    typedef struct packed {
        logic run;
        logic periodic;
        logic fast;
    } chan_cfg_t;

    typedef enum logic [1:0] {
        REG_LOAD  = 2'd0,
        REG_VALUE = 2'd1,
        REG_CTRL  = 2'd2,
        REG_CLEAR = 2'd3
    } chan_reg_e;

    function automatic logic [ADDR_W-1:0] chan_base(input int idx);
        case (idx)
            0:       return 8'h00;
            1:       return 8'h20;
            default: return 8'h80;
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] chan_reg_addr(input int idx, input chan_reg_e r);
        return chan_base(idx) + {4'h0, r, 2'b00};
    endfunction

    function automatic logic [BUS_W-1:0] cfg_to_word(input chan_cfg_t c);
        logic [BUS_W-1:0] w;
        w = '0;
        w[CTL_RUN_BIT]  = c.run;
        w[CTL_PER_BIT]  = c.periodic;
        w[CTL_FAST_BIT] = c.fast;
        return w;
    endfunction

    function automatic chan_cfg_t word_to_cfg(input logic [BUS_W-1:0] w);
        chan_cfg_t c;
        c.run      = w[CTL_RUN_BIT];
        c.periodic = w[CTL_PER_BIT];
        c.fast     = w[CTL_FAST_BIT];
        return c;
    endfunction
endpackage

// File: rtl/tmr_decode.sv
module tmr_decode
    import tmr_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output logic [NCH-1:0]    hit,
    output chan_reg_e         kind,
    output logic              stamp_lo,
    output logic              stamp_hi
);
    always_comb begin
        kind = chan_reg_e'(addr[3:2]);
        for (int i = 0; i < NCH; i++) begin
            hit[i] = (addr[7:4] == chan_base(i)[7:4]) && (addr[1:0] == 2'b00);
        end
        stamp_lo = (addr == STAMP_LO_ADDR);
        stamp_hi = (addr == STAMP_HI_ADDR);
    end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_load,
    input  logic             wr_ctrl,
    input  logic             wr_clear,
    input  logic [BUS_W-1:0] wdata,
    input  logic             tick_fast,
    input  logic             tick_slow,
    output logic [W-1:0]     load_q,
    output logic [W-1:0]     count,
    output chan_cfg_t        cfg,
    output logic             irq
);
    logic step;
    logic underflow;

    assign step      = cfg.run && (cfg.fast ? tick_fast : tick_slow);
    assign underflow = step && !wr_load && (count == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            load_q <= '0;
            count  <= '0;
            cfg    <= '0;
            irq    <= 1'b0;
        end else begin
            if (wr_ctrl) cfg <= word_to_cfg(wdata);
            if (wr_load) begin
                load_q <= wdata[W-1:0];
                count  <= wdata[W-1:0];
            end else if (step) begin
                if (count == '0) count <= cfg.periodic ? load_q : '1;
                else             count <= count - 1'b1;
            end
            if (underflow)     irq <= 1'b1;
            else if (wr_clear) irq <= 1'b0;
        end
    end
endmodule

// File: rtl/tmr_stamp.sv
module tmr_stamp #(
    parameter int W    = 40,
    parameter int LO_W = 32,
    localparam int HI_W = W - LO_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic            wr_hi,
    input  logic            en_in,
    input  logic            rd_lo,
    output logic [W-1:0]    count,
    output logic            run,
    output logic [HI_W-1:0] snap
);
    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            run   <= 1'b0;
            snap  <= '0;
        end else begin
            if (wr_hi)       run   <= en_in;
            if (run && tick) count <= count + 1'b1;
            if (rd_lo)       snap  <= count[W-1:LO_W];
        end
    end
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
    import tmr_pkg::*;
#(
    parameter int CH1_W      = 16,
    parameter int CH2_W      = 16,
    parameter int CH3_W      = 32,
    parameter int STAMP_W    = 40,
    parameter int STAMP_LO_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              tick_fast,
    input  logic              tick_slow,
    input  logic              tick_stamp,
    output logic [NCH-1:0]    irq
);
    localparam int STAMP_HI_W = STAMP_W - STAMP_LO_W;

    logic [NCH-1:0]        hit;
    chan_reg_e             kind;
    logic                  sel_lo;
    logic                  sel_hi;
    logic [BUS_W-1:0]      ch_load_w  [NCH];
    logic [BUS_W-1:0]      ch_count_w [NCH];
    chan_cfg_t             ch_cfg     [NCH];
    logic [STAMP_W-1:0]    stamp_cnt;
    logic                  stamp_run;
    logic [STAMP_HI_W-1:0] stamp_snap;
    logic [BUS_W-1:0]      rd_next;

    tmr_decode u_dec (
        .addr     (bus_addr),
        .hit      (hit),
        .kind     (kind),
        .stamp_lo (sel_lo),
        .stamp_hi (sel_hi)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        localparam int W = (i == 0) ? CH1_W : (i == 1) ? CH2_W : CH3_W;
        logic [W-1:0] ld;
        logic [W-1:0] cn;
        logic         irq_w;

        tmr_channel #(.W(W)) u_ch (
            .clk       (clk),
            .rst       (rst),
            .wr_load   (bus_wr && hit[i] && kind == REG_LOAD),
            .wr_ctrl   (bus_wr && hit[i] && kind == REG_CTRL),
            .wr_clear  (bus_wr && hit[i] && kind == REG_CLEAR),
            .wdata     (bus_wdata),
            .tick_fast (tick_fast),
            .tick_slow (tick_slow),
            .load_q    (ld),
            .count     (cn),
            .cfg       (ch_cfg[i]),
            .irq       (irq_w)
        );

        assign ch_load_w[i]  = BUS_W'(ld);
        assign ch_count_w[i] = BUS_W'(cn);
        assign irq[i]        = irq_w;
    end

    tmr_stamp #(.W(STAMP_W), .LO_W(STAMP_LO_W)) u_stamp (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick_stamp),
        .wr_hi (bus_wr && sel_hi),
        .en_in (bus_wdata[STAMP_EN_BIT]),
        .rd_lo (bus_rd && sel_lo),
        .count (stamp_cnt),
        .run   (stamp_run),
        .snap  (stamp_snap)
    );

    always_comb begin
        rd_next = '0;
        for (int i = 0; i < NCH; i++) begin
            if (hit[i]) begin
                case (kind)
                    REG_LOAD:  rd_next = ch_load_w[i];
                    REG_VALUE: rd_next = ch_count_w[i];
                    REG_CTRL:  rd_next = cfg_to_word(ch_cfg[i]);
                    default:   rd_next = '0;
                endcase
            end
        end
        if (sel_lo) rd_next = BUS_W'(stamp_cnt[STAMP_LO_W-1:0]);
        if (sel_hi) begin
            rd_next                   = '0;
            rd_next[STAMP_HI_W-1:0]   = stamp_snap;
            rd_next[STAMP_EN_BIT]     = stamp_run;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_next;
        else             bus_rdata <= '0;
    end
endmodule

// File: rtl/tmr_unit_chk.sv
module tmr_unit_chk
    import tmr_pkg::*;
#(
    parameter int STAMP_W = 40
) (
    input logic               clk,
    input logic               rst,
    input logic               bus_wr,
    input logic               bus_rd,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [BUS_W-1:0]   bus_rdata,
    input logic               tick_fast,
    input logic               tick_slow,
    input logic               tick_stamp,
    input logic [NCH-1:0]     irq,
    input logic [BUS_W-1:0]   ch_count [NCH],
    input logic [STAMP_W-1:0] stamp_cnt
);
    for (genvar i = 0; i < NCH; i++) begin : g_a
        assert_irq_clear_only_R6: assert property (@(posedge clk) disable iff (rst)
            $fell(irq[i]) |-> $past(bus_wr && bus_addr == chan_reg_addr(i, REG_CLEAR)));

        assert_irq_needs_tick_R5: assert property (@(posedge clk) disable iff (rst)
            $rose(irq[i]) |-> $past(tick_fast || tick_slow));

        assert_count_hold_R2: assert property (@(posedge clk) disable iff (rst)
            (!tick_fast && !tick_slow && !bus_wr) |=> $stable(ch_count[i]));
    end

    assert_stamp_step_R10: assert property (@(posedge clk) disable iff (rst)
        !$stable(stamp_cnt) |-> ($past(tick_stamp) && stamp_cnt == STAMP_W'($past(stamp_cnt) + 1'b1)));

    assert_rdata_idle_R12: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> bus_rdata == '0);
endmodule

bind tmr_unit tmr_unit_chk #(.STAMP_W(STAMP_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .tick_fast  (tick_fast),
    .tick_slow  (tick_slow),
    .tick_stamp (tick_stamp),
    .irq        (irq),
    .ch_count   (ch_count_w),
    .stamp_cnt  (stamp_cnt)
);

// File: tb/tb_tmr_unit.sv
module tb_tmr_unit;
    localparam int SW  = 14;
    localparam int SLO = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick_fast = 1'b0;
    logic        tick_slow = 1'b0;
    logic        tick_stamp = 1'b0;
    logic [2:0]  irq;

    int vectors = 0;
    int miscompares = 0;
    bit started = 0;
    bit done = 0;
    bit ticks_on = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    tmr_unit #(.STAMP_W(SW), .STAMP_LO_W(SLO)) dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick_fast(tick_fast), .tick_slow(tick_slow), .tick_stamp(tick_stamp),
        .irq(irq)
    );

    // Reference model state
    logic [7:0]    bases [3] = '{8'h00, 8'h20, 8'h80};
    logic [31:0]   m_ld  [3];
    logic [31:0]   m_cnt [3];
    bit            m_run [3];
    bit            m_per [3];
    bit            m_fast[3];
    bit            m_irq [3];
    logic [SW-1:0] m_st;
    bit            m_sten;
    logic [7:0]    m_snap;
    logic [31:0]   m_rd;
    bit            m_rdv;
    logic [7:0]    m_rdaddr;

    function automatic logic [31:0] msk(input int c);
        return (c == 2) ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    endfunction

    function automatic logic [31:0] mread(input logic [7:0] a);
        logic [31:0] r;
        r = 0;
        for (int c = 0; c < 3; c++) begin
            if (a == bases[c])        r = m_ld[c];
            if (a == bases[c] + 8'h4) r = m_cnt[c];
            if (a == bases[c] + 8'h8) r = {24'b0, m_run[c], m_per[c], 2'b00, m_fast[c], 3'b000};
        end
        if (a == 8'h60) r = 32'(m_st[SLO-1:0]);
        if (a == 8'h64) r = {23'b0, m_sten, m_snap};
        return r;
    endfunction

    function automatic string rtag(input logic [7:0] a);
        for (int c = 0; c < 3; c++) begin
            if (a == bases[c])        return "R7";
            if (a == bases[c] + 8'h4) return "R2";
            if (a == bases[c] + 8'h8) return "R1";
        end
        if (a == 8'h60 || a == 8'h64) return "R11";
        return "R12";
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < 3; c++) begin
                m_ld[c] = 0; m_cnt[c] = 0; m_run[c] = 0;
                m_per[c] = 0; m_fast[c] = 0; m_irq[c] = 0;
            end
            m_st = 0; m_sten = 0; m_snap = 0; m_rd = 0; m_rdv = 0;
        end else begin
            m_rdv    = bus_rd;
            m_rdaddr = bus_addr;
            m_rd     = bus_rd ? mread(bus_addr) : 32'h0;
            for (int c = 0; c < 3; c++) begin
                bit t, uf;
                t  = m_run[c] && (m_fast[c] ? tick_fast : tick_slow);
                uf = 0;
                if (bus_wr && bus_addr == bases[c]) begin
                    m_ld[c]  = bus_wdata & msk(c);
                    m_cnt[c] = bus_wdata & msk(c);
                end else if (t) begin
                    if (m_cnt[c] == 0) begin
                        uf = 1;
                        m_cnt[c] = m_per[c] ? m_ld[c] : msk(c);
                    end else begin
                        m_cnt[c] = m_cnt[c] - 1;
                    end
                end
                if (bus_wr && bus_addr == bases[c] + 8'h8) begin
                    m_run[c]  = bus_wdata[7];
                    m_per[c]  = bus_wdata[6];
                    m_fast[c] = bus_wdata[3];
                end
                if (uf) m_irq[c] = 1;
                else if (bus_wr && bus_addr == bases[c] + 8'hC) m_irq[c] = 0;
            end
            if (bus_rd && bus_addr == 8'h60) m_snap = 8'(m_st[SW-1:SLO]);
            if (m_sten && tick_stamp) m_st = m_st + 1'b1;
            if (bus_wr && bus_addr == 8'h64) m_sten = bus_wdata[8];
        end
        started = 1;
    end

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (started && !done) begin
            vectors++;
            if (irq !== {m_irq[2], m_irq[1], m_irq[0]}) begin
                miscompares++;
                $display("FAIL R5 irq actual=%b expected=%b at cycle %0d",
                         irq, {m_irq[2], m_irq[1], m_irq[0]}, cyc);
            end
            vectors++;
            if (bus_rdata !== m_rd) begin
                miscompares++;
                $display("FAIL %s rdata addr=%h actual=%h expected=%h valid=%0d",
                         rtag(m_rdaddr), m_rdaddr, bus_rdata, m_rd, m_rdv);
            end
        end
    end

    always @(negedge clk) begin
        cyc++;
        tick_fast  = ticks_on && (cyc % 3 == 0);
        tick_slow  = ticks_on && (cyc % 7 == 0);
        tick_stamp = ticks_on && (cyc % 2 == 1);
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a);
        @(negedge clk);
        bus_rd = 1; bus_addr = a;
        @(negedge clk);
        bus_rd = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL R12 watchdog actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        logic [15:0] lfsr;
        lfsr = 16'hACE1;
        idle(4);
        @(negedge clk);
        rst = 0;
        // Reset state: every register reads zero (R12, R9 map)
        foreach (bases[c]) begin
            rd(bases[c]); rd(bases[c] + 8'h4); rd(bases[c] + 8'h8);
        end
        rd(8'h60); rd(8'h64); rd(8'h40);
        ticks_on = 1;

        // R3 periodic fast channel 1, load 4 -> period of 5 ticks; R1 readback
        wr(8'h00, 32'h4);
        wr(8'h08, 32'hFFFF_FFC8);
        rd(8'h08);
        repeat (8) begin rd(8'h04); idle(2); end
        wr(8'h0C, 32'h0);          // R6 clear with any data
        idle(20);
        wr(8'h0C, 32'hDEAD_BEEF);

        // R4 one-shot slow channel 2 wraps to 0xFFFF; R8 truncation
        wr(8'h20, 32'h0001_0002);
        wr(8'h28, 32'h0000_0080);
        repeat (10) begin rd(8'h24); idle(3); end
        rd(8'h20);
        wr(8'h2C, 32'h1);

        // R8 32-bit channel 3 one-shot fast wraps to all ones
        wr(8'h80, 32'h3);
        wr(8'h88, 32'h88);
        repeat (8) begin rd(8'h84); idle(2); end
        wr(8'h84, 32'h1234);       // R7 value register write ignored
        rd(8'h84);
        wr(8'h80, 32'h0);          // R7 load overrides count immediately
        rd(8'h84);

        // R1 stopped channel holds
        wr(8'h88, 32'h48);
        idle(9);
        rd(8'h84); rd(8'h84);

        // R10 R11 timestamp enable, snapshot of upper bits across carries
        wr(8'h64, 32'h100);
        repeat (30) begin rd(8'h60); rd(8'h64); idle(5); end
        wr(8'h64, 32'h0);
        idle(6);
        rd(8'h60); rd(8'h64);

        // Varied pattern: R6 clears racing underflows, mixed writes
        wr(8'h00, 32'h1);
        wr(8'h08, 32'hC8);
        wr(8'h28, 32'hC0);
        wr(8'h88, 32'hC8);
        wr(8'h64, 32'h100);
        for (int k = 0; k < 150; k++) begin
            int c;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            c = lfsr[1:0] % 3;
            case (lfsr[4:2])
                3'd0: wr(bases[c], {16'h0, 8'h0, lfsr[15:8] & 8'h07});
                3'd1: wr(bases[c] + 8'hC, 32'(lfsr));
                3'd2: wr(bases[c] + 8'h8, {24'h0, lfsr[15], lfsr[14], 2'b0, lfsr[13], 3'b0} | 32'h80);
                3'd3: rd(bases[c] + 8'h4);
                3'd4: rd(8'h60);
                3'd5: rd(8'h64);
                3'd6: rd({lfsr[15:10], 2'b00});
                default: idle(1);
            endcase
        end
        idle(4);
        finish_run();
    end
endmodule